// File: doc/BRIEF.md
# Core Hand-over Power Sequencer

On a chip that holds several cores running the same instruction set, exactly one core executes at a time and every other core is fully powered off. This block moves execution from the running core to a chosen one. A move request names a target core. The block samples it only on a timeslice tick while it is idle. It then asks the running core to drain its pipeline and write its dirty L1 data lines back to the shared L2. After that it brings up the target's supply in several equal steps, which limits supply-rail noise. When the target's supply is good, it releases the target to fetch from a fixed entry address. Only after that does it remove power from the core that has just been left.

The clock is shared and keeps running for all cores. The block switches only the power segments of each core. The defaults are four steps of 250 cycles, about 1000 cycles in all for a power-up. A request that names the core already running is acknowledged with no other action. Requests that arrive while a move is under way are dropped.

Top module: `core_handover_seq`

## Requirements
- R1: After reset the boot core (index 0) is running and has all its power segments on, every other core is off, and busy, req_ack, flush_req and core_launch are low.
- R2: A request is taken only in a cycle where slice_tick and req_valid are both high and the block is idle. A request without slice_tick has no effect.
- R3: A request for the core already running raises req_ack for exactly one cycle, in the cycle after it is taken. Power, run and busy do not change.
- R4: When a move request is taken, busy rises in the next cycle. From that cycle on, flush_req of the running core stays high until that core's flush_done is seen. The core keeps running during the drain.
- R5: In the cycle after flush_done of the running core is seen, its core_run goes low and the target's first power segment turns on.
- R6: pwr_en bit c*STAGES+k is segment k of core c. The target's segment k turns on k*STAGE_CYCLES cycles after segment 0. Segments turn on in order and none turns off during the ramp.
- R7: The target is released only once its last segment has been on for STAGE_CYCLES cycles and its pwr_good is high. core_run of the target rises in the cycle after that condition holds.
- R8: core_launch is high for exactly the first cycle in which the target runs, and launch_pc always carries the entry address (0x00001000 by default).
- R9: In the cycle after core_launch, every segment of the old core is off, active_core shows the target, busy is low and req_ack is high for that one cycle.
- R10: No two cores ever run at once, and a core runs only while all of its segments are on.
- R11: A request taken while busy is high has no effect on the move in progress or on the cycles that follow it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slice_tick | input | 1 | Timeslice boundary strobe |
| req_valid | input | 1 | Move request present |
| req_core | input | $clog2(NCORES) | Target core index |
| req_ack | output | 1 | One-cycle acknowledge of a finished or null move |
| busy | output | 1 | Move in progress |
| active_core | output | $clog2(NCORES) | Index of the core that owns execution |
| flush_req | output | NCORES | Per-core drain and write-back request |
| flush_done | input | NCORES | Per-core drain finished |
| pwr_en | output | NCORES*STAGES | Per-core staged power segment enables |
| pwr_good | input | NCORES | Per-core supply stable |
| core_run | output | NCORES | Per-core execute release |
| core_launch | output | 1 | Strobe in the first cycle of the new core |
| launch_pc | output | PCW | Entry address for the new core |

## Verification
Some properties are checked by assertions on every cycle. These are: a single runner, a runner always fully powered, segments that stay a thermometer code, a flush request that holds until its done signal, a launch strobe of one cycle, and the retire/acknowledge in the cycle after launch. The bench's scenarios are needed for the rest. These are the exact stage spacing of 250 cycles, the wait on a late power-good, dropped requests during a drain, ticks with no request, null moves, and the fast path where flush and power-good are already high.

// File: rtl/core_seq_pkg.sv
package core_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FLUSH,
    ST_RAMP,
    ST_PGWAIT,
    ST_LAUNCH
  } seq_state_e;

  // total ramp length before power-good is considered
  function automatic int unsigned ramp_span(input int unsigned stages, input int unsigned per_stage);
    return stages * per_stage;
  endfunction

  // true when a segment vector is a thermometer code (0..01..1)
  function automatic bit is_thermo(input logic [31:0] segs, input int unsigned width);
    logic [31:0] m;
    m = (width >= 32) ? 32'hFFFF_FFFF : ((32'd1 << width) - 32'd1);
    return (((segs & m) + 32'd1) & (segs & m)) == 32'd0;
  endfunction
endpackage

// File: rtl/seq_stage_timer.sv
module seq_stage_timer #(
  parameter int STAGES       = 4,
  parameter int STAGE_CYCLES = 250
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       run,
  output logic [$clog2(STAGES)-1:0]  stage_idx,
  output logic                       step_ev,
  output logic                       ramp_done
);
  localparam int CNTW = $clog2(STAGE_CYCLES);
  localparam int STGW = $clog2(STAGES);

  logic [CNTW-1:0] cnt_q;
  logic [STGW-1:0] stage_q;

  assign step_ev   = run && (cnt_q == CNTW'(STAGE_CYCLES - 1));
  assign ramp_done = step_ev && (stage_q == STGW'(STAGES - 1));
  assign stage_idx = stage_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt_q   <= '0;
      stage_q <= '0;
    end else if (step_ev) begin
      cnt_q <= '0;
      if (!ramp_done) stage_q <= stage_q + STGW'(1);
    end else begin
      cnt_q <= cnt_q + CNTW'(1);
    end
  end

  // R6: the dwell counter never passes the per-stage length
  p_cnt_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNTW'(STAGE_CYCLES - 1));
  // R6: a step always advances the stage or ends the ramp
  p_stage_adv_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (step_ev && !ramp_done) |=> (stage_idx == $past(stage_idx) + STGW'(1)));
endmodule

// File: rtl/seq_rail_bank.sv
module seq_rail_bank #(
  parameter int NCORES    = 4,
  parameter int STAGES    = 4,
  parameter int BOOT_CORE = 0
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        set_en,
  input  logic [$clog2(NCORES)-1:0]   set_core,
  input  logic [$clog2(STAGES)-1:0]   set_seg,
  input  logic                        clr_en,
  input  logic [$clog2(NCORES)-1:0]   clr_core,
  output logic [NCORES*STAGES-1:0]    pwr_en
);
  localparam int IDXW = $clog2(NCORES);

  for (genvar c = 0; c < NCORES; c++) begin : g_core
    logic [STAGES-1:0] segs_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        segs_q <= (c == BOOT_CORE) ? '1 : '0;
      end else if (clr_en && clr_core == IDXW'(c)) begin
        segs_q <= '0;
      end else if (set_en && set_core == IDXW'(c)) begin
        segs_q[set_seg] <= 1'b1;
      end
    end

    assign pwr_en[c*STAGES +: STAGES] = segs_q;

    // R6: segments of every core form a thermometer code
    p_thermo_r6: assert property (@(posedge clk) disable iff (!rst_n)
      core_seq_pkg::is_thermo(32'(segs_q), STAGES));
  end
endmodule

// File: rtl/core_handover_seq.sv
module core_handover_seq #(
  parameter int          NCORES       = 4,
  parameter int          STAGES       = 4,
  parameter int          STAGE_CYCLES = 250,
  parameter int          PCW          = 32,
  parameter logic [31:0] ENTRY_PC     = 32'h0000_1000,
  parameter int          BOOT_CORE    = 0
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       slice_tick,
  input  logic                       req_valid,
  input  logic [$clog2(NCORES)-1:0]  req_core,
  output logic                       req_ack,
  output logic                       busy,
  output logic [$clog2(NCORES)-1:0]  active_core,
  output logic [NCORES-1:0]          flush_req,
  input  logic [NCORES-1:0]          flush_done,
  output logic [NCORES*STAGES-1:0]   pwr_en,
  input  logic [NCORES-1:0]          pwr_good,
  output logic [NCORES-1:0]          core_run,
  output logic                       core_launch,
  output logic [PCW-1:0]             launch_pc
);
  import core_seq_pkg::*;

  localparam int IDXW = $clog2(NCORES);
  localparam int STGW = $clog2(STAGES);

  seq_state_e      st_q;
  logic [IDXW-1:0] cur_q, tgt_q;
  logic            ack_q;
  logic [NCORES-1:0] run_q;

  // named internal events
  logic accept_ev, null_ev, move_ev, drained_ev, ramp_live, pg_ev, launch_ev;
  logic step_ev, ramp_done;
  logic [STGW-1:0] stage_idx;
  logic            seg_set_en;
  logic [STGW-1:0] seg_set_idx;

  assign accept_ev  = (st_q == ST_IDLE) && slice_tick && req_valid;
  assign null_ev    = accept_ev && ((req_core == cur_q) || (32'(req_core) >= NCORES));
  assign move_ev    = accept_ev && !null_ev;
  assign drained_ev = (st_q == ST_FLUSH) && flush_done[cur_q];
  assign ramp_live  = (st_q == ST_RAMP);
  assign pg_ev      = (st_q == ST_PGWAIT) && pwr_good[tgt_q];
  assign launch_ev  = (st_q == ST_LAUNCH);

  seq_stage_timer #(.STAGES(STAGES), .STAGE_CYCLES(STAGE_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(ramp_live),
    .stage_idx(stage_idx), .step_ev(step_ev), .ramp_done(ramp_done)
  );

  assign seg_set_en  = drained_ev || (step_ev && !ramp_done);
  assign seg_set_idx = drained_ev ? '0 : stage_idx + STGW'(1);

  seq_rail_bank #(.NCORES(NCORES), .STAGES(STAGES), .BOOT_CORE(BOOT_CORE)) u_rails (
    .clk(clk), .rst_n(rst_n),
    .set_en(seg_set_en), .set_core(tgt_q), .set_seg(seg_set_idx),
    .clr_en(launch_ev), .clr_core(cur_q),
    .pwr_en(pwr_en)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cur_q <= IDXW'(BOOT_CORE);
      tgt_q <= IDXW'(BOOT_CORE);
      ack_q <= 1'b0;
      run_q <= NCORES'(1) << BOOT_CORE;
    end else begin
      ack_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (null_ev) ack_q <= 1'b1;
          if (move_ev) begin
            tgt_q <= req_core;
            st_q  <= ST_FLUSH;
          end
        end
        ST_FLUSH: if (drained_ev) begin
          run_q[cur_q] <= 1'b0;
          st_q         <= ST_RAMP;
        end
        ST_RAMP: if (ramp_done) st_q <= ST_PGWAIT;
        ST_PGWAIT: if (pg_ev) begin
          run_q[tgt_q] <= 1'b1;
          st_q         <= ST_LAUNCH;
        end
        ST_LAUNCH: begin
          cur_q <= tgt_q;
          ack_q <= 1'b1;
          st_q  <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy        = (st_q != ST_IDLE);
  assign req_ack     = ack_q;
  assign active_core = cur_q;
  assign flush_req   = (st_q == ST_FLUSH) ? (NCORES'(1) << cur_q) : '0;
  assign core_run    = run_q;
  assign core_launch = launch_ev;
  assign launch_pc   = PCW'(ENTRY_PC);

  // R10: never more than one core executing
  p_single_runner_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(core_run) <= 1);
  for (genvar i = 0; i < NCORES; i++) begin : g_chk
    // R10: a running core has every segment powered
    p_run_powered_r10: assert property (@(posedge clk) disable iff (!rst_n)
      core_run[i] |-> (&pwr_en[i*STAGES +: STAGES]));
  end
  // R4: a drain request holds until its done is seen
  p_flush_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((flush_req != '0) && ((flush_req & flush_done) == '0)) |=> $stable(flush_req));
  // R8: launch strobe lasts one cycle
  p_launch_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    core_launch |=> !core_launch);
  // R9: retire and acknowledge follow the launch
  p_retire_r9: assert property (@(posedge clk) disable iff (!rst_n)
    core_launch |=> (!busy && req_ack && $countones(core_run) == 1));
  // R3: acknowledge only when idle
  p_ack_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |-> !busy);
  // R11: the target cannot change while a move is under way
  p_hold_target_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !core_launch) |=> $stable(tgt_q));
endmodule

// File: tb/sim_core_handover_seq.sv
module sim_core_handover_seq;
  localparam int NC = 4;
  localparam int ST = 4;
  localparam int SC = 250;
  localparam logic [31:0] PC = 32'h0000_1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic slice_tick = 1'b0, req_valid = 1'b0;
  logic [1:0] req_core = '0;
  logic req_ack, busy, core_launch;
  logic [1:0] active_core;
  logic [NC-1:0] flush_req, core_run;
  logic [NC-1:0] flush_done = '0, pwr_good = '0;
  logic [NC*ST-1:0] pwr_en;
  logic [31:0] launch_pc;

  int nvec = 0, nfail = 0, wd = 0;

  always #10 clk = ~clk;

  core_handover_seq u0 (
    .clk(clk), .rst_n(rst_n), .slice_tick(slice_tick), .req_valid(req_valid),
    .req_core(req_core), .req_ack(req_ack), .busy(busy), .active_core(active_core),
    .flush_req(flush_req), .flush_done(flush_done), .pwr_en(pwr_en),
    .pwr_good(pwr_good), .core_run(core_run), .core_launch(core_launch),
    .launch_pc(launch_pc)
  );

  // behavioural reference: phase 0 idle, 1 drain, 2 ramp, 3 power-good wait, 4 launch
  int m_ph, m_cur, m_tgt, m_el;
  logic [NC-1:0] m_run;
  logic [NC*ST-1:0] m_pwr;
  logic m_ack;

  always @(posedge clk) begin : model
    bit nack;
    if (!rst_n) begin
      m_ph = 0; m_cur = 0; m_tgt = 0; m_el = 0;
      m_run = 4'b0001;
      m_pwr = '0;
      for (int s = 0; s < ST; s++) m_pwr[s] = 1'b1;
      m_ack = 1'b0;
    end else begin
      nack = 1'b0;
      case (m_ph)
        0: if (slice_tick && req_valid) begin
             if (int'(req_core) == m_cur) nack = 1'b1;
             else begin m_tgt = int'(req_core); m_ph = 1; end
           end
        1: if (flush_done[m_cur]) begin
             m_run[m_cur] = 1'b0;
             m_pwr[m_tgt*ST] = 1'b1;
             m_el = 0;
             m_ph = 2;
           end
        2: begin
             m_el++;
             if (m_el == ST*SC) m_ph = 3;
             else if (m_el % SC == 0) m_pwr[m_tgt*ST + m_el/SC] = 1'b1;
           end
        3: if (pwr_good[m_tgt]) begin m_run[m_tgt] = 1'b1; m_ph = 4; end
        default: begin
             for (int s = 0; s < ST; s++) m_pwr[m_cur*ST + s] = 1'b0;
             m_cur = m_tgt;
             nack = 1'b1;
             m_ph = 0;
           end
      endcase
      m_ack = nack;
    end
  end

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s act=%h exp=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  logic cmp_on = 1'b0;
  always @(negedge clk) begin
    if (cmp_on) begin
      chk("R2 R11", "busy", 64'(busy), 64'(m_ph != 0));
      chk("R3 R9", "req_ack", 64'(req_ack), 64'(m_ack));
      chk("R9", "active_core", 64'(active_core), 64'(m_cur));
      chk("R4", "flush_req", 64'(flush_req), (m_ph == 1) ? (64'd1 << m_cur) : 64'd0);
      chk("R6 R9", "pwr_en", 64'(pwr_en), 64'(m_pwr));
      chk("R5 R7 R10", "core_run", 64'(core_run), 64'(m_run));
      chk("R8", "core_launch", 64'(core_launch), 64'(m_ph == 4));
      chk("R8", "launch_pc", 64'(launch_pc), 64'(PC));
    end
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 20000) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic request(input int core, input bit tick);
    @(negedge clk);
    slice_tick = tick; req_valid = 1'b1; req_core = 2'(core);
    @(negedge clk);
    slice_tick = 1'b0; req_valid = 1'b0;
  endtask

  task automatic pulse_flush();
    flush_done = '1;
    cyc(1);
    flush_done = '0;
  endtask

  initial begin
    cyc(3);
    // R1 reset state
    chk("R1", "reset run", 64'(core_run), 64'h1);
    chk("R1", "reset pwr", 64'(pwr_en), 64'h000F);
    chk("R1", "reset busy", 64'(busy), 64'h0);
    chk("R1", "reset ack", 64'(req_ack), 64'h0);
    chk("R1", "reset flush", 64'(flush_req), 64'h0);
    chk("R1", "reset launch", 64'(core_launch), 64'h0);
    @(posedge clk); rst_n = 1'b1;
    @(negedge clk); cmp_on = 1'b1;
    cyc(2);
    // R2: request with no tick, and tick without request
    request(2, 1'b0);
    @(negedge clk); slice_tick = 1'b1; @(negedge clk); slice_tick = 1'b0;
    cyc(3);
    // R3: null move to the running core
    request(0, 1'b1);
    cyc(3);
    // R4 R5 R6 R7 R11: slow drain with a dropped request, late power-good
    request(2, 1'b1);
    cyc(5);
    request(3, 1'b1);
    cyc(3);
    pulse_flush();
    cyc(ST*SC + 12);
    pwr_good = '1;
    cyc(2);
    pwr_good = '0;
    cyc(4);
    // fast path: flush_done and pwr_good already high
    flush_done = '1; pwr_good = '1;
    request(1, 1'b1);
    cyc(ST*SC + 8);
    flush_done = '0; pwr_good = '0;
    cyc(3);
    // third move, then a null move on the new core
    request(3, 1'b1);
    cyc(2);
    pulse_flush();
    cyc(ST*SC + 3);
    pwr_good = 4'b1000;
    cyc(4);
    pwr_good = '0;
    request(3, 1'b1);
    cyc(4);
    chk("R9", "final active", 64'(active_core), 64'd3);
    chk("R10", "final run", 64'(core_run), 64'h8);
    chk("R9", "final pwr", 64'(pwr_en), 64'hF000);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule